// File: doc/BRIEF.md
# Self-Timed Program Sequencer with Ready/Busy Status

This block sits behind the serial command decoder of a small non-volatile memory. The decoder hands it one strobe per complete instruction, together with the opcode, the address, the data and the organisation mode. The sequencer keeps a write-enable latch and accepts programming commands only while that latch is set. It holds an accepted command until chip select falls, and then runs an internal programming cycle of fixed length against a register-file model of the array. At the end of that cycle the array is updated in a single clock.

When chip select is raised again while a cycle is running, the serial data output reports status. It shows 0 while the cycle runs and switches to 1 once the array has been updated. The status output is released when chip select falls, or when a new start bit arrives after the cycle has finished. The cycle length is a parameter counted in system clocks. Silicon uses a value of a few milliseconds; a bench uses a much shorter one.

Top module: `nvm_prog_seq`

## Requirements
- R1: After reset the write-enable latch is cleared, no cycle is running, `dout_oe_o` is 0 and `arr_we_o` is 0.
- R2: Opcode 0 sets the write-enable latch and opcode 1 clears it. Opcodes 2 (write), 3 (write-all), 4 (erase) and 5 (erase-all) leave the array unchanged while the latch is clear.
- R3: An accepted programming command starts a cycle only on the next falling edge of `cs_i`. The cycle lasts `PROG_CLKS` clocks, and the array changes only at its end, through one `arr_we_o` pulse.
- R4: With `org_word_i`=1, a write stores the 16-bit data at word address `cmd_addr_i[5:0]` and leaves every other word unchanged.
- R5: With `org_word_i`=0, a write stores `cmd_data_i[7:0]` into one byte. The byte address `cmd_addr_i[6:0]` selects word `cmd_addr_i[6:1]`; `cmd_addr_i[0]`=0 selects bits 7:0 and 1 selects bits 15:8. The other byte of that word is unchanged.
- R6: An erase sets the addressed word (word mode) or byte (byte mode) to all ones.
- R7: A write-all stores the pattern in every word: `cmd_data_i` in word mode, and `cmd_data_i[7:0]` in both bytes in byte mode.
- R8: An erase-all sets every bit of the array to 1.
- R9: If `cs_i` rises while a cycle runs, `dout_oe_o` goes to 1 from the next clock. `dout_o` is then 0 until the cycle ends and 1 afterwards.
- R10: If `cs_i` is raised only after the cycle has ended, `dout_oe_o` stays 0.
- R11: Command strobes received during a cycle are discarded: they change neither the latch nor the pending command.
- R12: Status output is released one clock after `cs_i` falls, or one clock after a `start_bit_i` pulse that arrives while no cycle runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous power-on reset |
| cs_i | input | 1 | Chip select, synchronous to clk_i |
| start_bit_i | input | 1 | Pulse: decoder saw a start bit |
| cmd_valid_i | input | 1 | Pulse: a complete instruction was decoded |
| cmd_op_i | input | 3 | Opcode: 0 enable, 1 disable, 2 write, 3 write-all, 4 erase, 5 erase-all |
| cmd_addr_i | input | 7 | Byte address (byte mode) or word address in bits 5:0 (word mode) |
| cmd_data_i | input | 16 | Write data |
| org_word_i | input | 1 | 1: 16-bit organisation, 0: 8-bit organisation |
| rd_addr_i | input | 6 | Array read word address |
| rd_data_o | output | 16 | Array read data |
| arr_we_o | output | 1 | Array write strobe at the end of a cycle |
| arr_all_o | output | 1 | Write applies to every word |
| arr_addr_o | output | 6 | Array word address |
| arr_bmask_o | output | 2 | Byte lane enables, bit 0 = bits 7:0 |
| arr_wdata_o | output | 16 | Array write data |
| dout_o | output | 1 | Status bit: 0 busy, 1 ready |
| dout_oe_o | output | 1 | Status output enable |

## Verification
Two events can land on the same clock edge: the rising edge of chip select and the end of the programming cycle. If both are seen together, a status window could open showing "ready" and skip "busy" altogether. The bench raises chip select one clock into a short cycle and counts the busy samples, which must equal one less than the cycle length. A separate property requires that every opening of the status window begins with a busy value. Commands that arrive in the middle of a cycle are judged by what happens later: a disable sent during the cycle must leave a following write effective, and a write sent during the cycle must never reach the array.

// File: rtl/nvm_seq_pkg.sv
package nvm_seq_pkg;
  typedef enum logic [2:0] {
    OP_WEN   = 3'd0,
    OP_WDS   = 3'd1,
    OP_WRITE = 3'd2,
    OP_WRAL  = 3'd3,
    OP_ERASE = 3'd4,
    OP_ERAL  = 3'd5
  } op_e;

  function automatic logic is_prog(op_e op);
    return (op == OP_WRITE) || (op == OP_WRAL) || (op == OP_ERASE) || (op == OP_ERAL);
  endfunction
endpackage

// File: rtl/nvm_wel_ctrl.sv
module nvm_wel_ctrl
  import nvm_seq_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cmd_valid_i,
  input  op_e  cmd_op_i,
  input  logic busy_i,
  output logic wel_o,
  output logic accept_o
);
  logic cmd_live;

  assign cmd_live = cmd_valid_i & ~busy_i;
  assign accept_o = cmd_live & wel_o & is_prog(cmd_op_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) wel_o <= 1'b0;
    else if (cmd_live && cmd_op_i == OP_WEN) wel_o <= 1'b1;
    else if (cmd_live && cmd_op_i == OP_WDS) wel_o <= 1'b0;
  end
endmodule

// File: rtl/nvm_cycle_timer.sv
module nvm_cycle_timer
  import nvm_seq_pkg::*;
#(
  parameter int WORDS     = 64,
  parameter int WORD_W    = 16,
  parameter int PROG_CLKS = 5000,
  localparam int BYTE_W   = WORD_W / 2,
  localparam int WADDR_W  = $clog2(WORDS),
  localparam int BADDR_W  = WADDR_W + 1,
  localparam int CNT_W    = $clog2(PROG_CLKS + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cs_i,
  input  logic               cmd_valid_i,
  input  logic               accept_i,
  input  op_e                cmd_op_i,
  input  logic [BADDR_W-1:0] cmd_addr_i,
  input  logic [WORD_W-1:0]  cmd_data_i,
  input  logic               org_word_i,
  output logic               cs_rise_o,
  output logic               cs_fall_o,
  output logic               pend_o,
  output logic               busy_o,
  output logic               done_o,
  output logic               arr_we_o,
  output logic               arr_all_o,
  output logic [WADDR_W-1:0] arr_addr_o,
  output logic [1:0]         arr_bmask_o,
  output logic [WORD_W-1:0]  arr_wdata_o
);
  logic               cs_q;
  logic [CNT_W-1:0]   cnt_q;
  op_e                op_q;
  logic [BADDR_W-1:0] addr_q;
  logic [WORD_W-1:0]  data_q;
  logic               org_q;
  logic               start;

  assign cs_rise_o = cs_i & ~cs_q;
  assign cs_fall_o = cs_q & ~cs_i;
  assign start     = cs_fall_o & pend_o & ~busy_o;
  assign done_o    = busy_o & (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cs_q <= 1'b0;
    else         cs_q <= cs_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_o <= 1'b0;
      op_q   <= OP_WDS;
      addr_q <= '0;
      data_q <= '0;
      org_q  <= 1'b1;
    end else if (start) begin
      pend_o <= 1'b0;
    end else if (accept_i) begin
      pend_o <= 1'b1;
      op_q   <= cmd_op_i;
      addr_q <= cmd_addr_i;
      data_q <= cmd_data_i;
      org_q  <= org_word_i;
    end else if (cmd_valid_i && !busy_o) begin
      // any other complete instruction cancels a command not yet launched
      pend_o <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o <= 1'b0;
      cnt_q  <= '0;
    end else if (start) begin
      busy_o <= 1'b1;
      cnt_q  <= CNT_W'(PROG_CLKS - 1);
    end else if (busy_o) begin
      if (cnt_q == '0) busy_o <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end
  end

  logic [WORD_W-1:0] pattern;
  logic [1:0]        lane;

  assign pattern = org_q ? data_q : {2{data_q[BYTE_W-1:0]}};
  assign lane    = org_q ? 2'b11 : (addr_q[0] ? 2'b10 : 2'b01);

  always_comb begin
    arr_we_o    = done_o;
    arr_all_o   = 1'b0;
    arr_addr_o  = org_q ? addr_q[WADDR_W-1:0] : addr_q[BADDR_W-1:1];
    arr_bmask_o = lane;
    arr_wdata_o = pattern;
    unique case (op_q)
      OP_WRAL: begin
        arr_all_o   = 1'b1;
        arr_bmask_o = 2'b11;
      end
      OP_ERASE: arr_wdata_o = '1;
      OP_ERAL: begin
        arr_all_o   = 1'b1;
        arr_bmask_o = 2'b11;
        arr_wdata_o = '1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/nvm_status_out.sv
module nvm_status_out (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_rise_i,
  input  logic cs_fall_i,
  input  logic start_bit_i,
  input  logic busy_i,
  input  logic done_i,
  output logic dout_o,
  output logic dout_oe_o
);
  logic show_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) show_q <= 1'b0;
    else if (cs_fall_i || (start_bit_i && !busy_i)) show_q <= 1'b0;
    else if (cs_rise_i && busy_i && !done_i) show_q <= 1'b1;
  end

  assign dout_oe_o = show_q;
  assign dout_o    = show_q & ~busy_i;
endmodule

// File: rtl/nvm_array_model.sv
module nvm_array_model #(
  parameter int WORDS    = 64,
  parameter int WORD_W   = 16,
  localparam int BYTE_W  = WORD_W / 2,
  localparam int WADDR_W = $clog2(WORDS)
) (
  input  logic               clk_i,
  input  logic               we_i,
  input  logic               all_i,
  input  logic [WADDR_W-1:0] addr_i,
  input  logic [1:0]         bmask_i,
  input  logic [WORD_W-1:0]  wdata_i,
  input  logic [WADDR_W-1:0] rd_addr_i,
  output logic [WORD_W-1:0]  rd_data_o
);
  logic [WORD_W-1:0] mem [WORDS];

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    for (genvar b = 0; b < 2; b++) begin : g_lane
      always_ff @(posedge clk_i) begin
        if (we_i && bmask_i[b] && (all_i || addr_i == WADDR_W'(w)))
          mem[w][b*BYTE_W +: BYTE_W] <= wdata_i[b*BYTE_W +: BYTE_W];
      end
    end
  end

  assign rd_data_o = mem[rd_addr_i];
endmodule

// File: rtl/nvm_prog_seq.sv
module nvm_prog_seq
  import nvm_seq_pkg::*;
#(
  parameter int WORDS     = 64,
  parameter int WORD_W    = 16,
  parameter int PROG_CLKS = 5000,
  localparam int WADDR_W  = $clog2(WORDS),
  localparam int BADDR_W  = WADDR_W + 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cs_i,
  input  logic               start_bit_i,
  input  logic               cmd_valid_i,
  input  logic [2:0]         cmd_op_i,
  input  logic [BADDR_W-1:0] cmd_addr_i,
  input  logic [WORD_W-1:0]  cmd_data_i,
  input  logic               org_word_i,
  input  logic [WADDR_W-1:0] rd_addr_i,
  output logic [WORD_W-1:0]  rd_data_o,
  output logic               arr_we_o,
  output logic               arr_all_o,
  output logic [WADDR_W-1:0] arr_addr_o,
  output logic [1:0]         arr_bmask_o,
  output logic [WORD_W-1:0]  arr_wdata_o,
  output logic               dout_o,
  output logic               dout_oe_o
);
  op_e  op;
  logic wel_w, accept_w, pend_w, busy_w, done_w, cs_rise_w, cs_fall_w;

  assign op = op_e'(cmd_op_i);

  nvm_wel_ctrl u_wel (
    .clk_i, .rst_ni, .cmd_valid_i, .cmd_op_i(op), .busy_i(busy_w),
    .wel_o(wel_w), .accept_o(accept_w)
  );

  nvm_cycle_timer #(.WORDS(WORDS), .WORD_W(WORD_W), .PROG_CLKS(PROG_CLKS)) u_tmr (
    .clk_i, .rst_ni, .cs_i, .cmd_valid_i, .accept_i(accept_w), .cmd_op_i(op),
    .cmd_addr_i, .cmd_data_i, .org_word_i,
    .cs_rise_o(cs_rise_w), .cs_fall_o(cs_fall_w), .pend_o(pend_w),
    .busy_o(busy_w), .done_o(done_w),
    .arr_we_o, .arr_all_o, .arr_addr_o, .arr_bmask_o, .arr_wdata_o
  );

  nvm_status_out u_stat (
    .clk_i, .rst_ni, .cs_rise_i(cs_rise_w), .cs_fall_i(cs_fall_w), .start_bit_i,
    .busy_i(busy_w), .done_i(done_w), .dout_o, .dout_oe_o
  );

  nvm_array_model #(.WORDS(WORDS), .WORD_W(WORD_W)) u_arr (
    .clk_i, .we_i(arr_we_o), .all_i(arr_all_o), .addr_i(arr_addr_o),
    .bmask_i(arr_bmask_o), .wdata_i(arr_wdata_o), .rd_addr_i, .rd_data_o
  );
endmodule

// File: rtl/nvm_prog_seq_chk.sv
module nvm_prog_seq_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic cs_i,
  input logic cmd_valid_i,
  input logic busy_i,
  input logic pend_i,
  input logic wel_i,
  input logic arr_we_i,
  input logic dout_i,
  input logic dout_oe_i
);
  // R3
  we_single_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arr_we_i |=> !arr_we_i);
  // R3
  start_on_cs_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_i) |-> !$past(cs_i));
  // R2
  we_needs_enable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arr_we_i |-> wel_i);
  // R9
  status_opens_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dout_oe_i) |-> !dout_i);
  // R11
  busy_drops_cmd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && cmd_valid_i) |=> !pend_i);
  // R11
  wel_held_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && $past(busy_i)) |-> $stable(wel_i));
  // R12
  status_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dout_oe_i && !cs_i) |=> !dout_oe_i);
endmodule

bind nvm_prog_seq nvm_prog_seq_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cs_i(cs_i), .cmd_valid_i(cmd_valid_i),
  .busy_i(busy_w), .pend_i(pend_w), .wel_i(wel_w), .arr_we_i(arr_we_o),
  .dout_i(dout_o), .dout_oe_i(dout_oe_o)
);

// File: tb/nvm_prog_seq_tb.sv
module nvm_prog_seq_tb;
  localparam int P  = 20;
  localparam int NV = 12;
  // {op[48:46], org[45], addr[44:38], data[37:22], chk word[21:16], expected[15:0]}
  localparam logic [48:0] VEC [NV] = '{
    {3'd5, 1'b1, 7'd0,  16'h0000, 6'd3,  16'hFFFF},
    {3'd2, 1'b1, 7'd3,  16'h1234, 6'd3,  16'h1234},
    {3'd2, 1'b1, 7'd4,  16'hABCD, 6'd4,  16'hABCD},
    {3'd2, 1'b0, 7'd7,  16'h005A, 6'd3,  16'h5A34},
    {3'd2, 1'b0, 7'd8,  16'h0077, 6'd4,  16'hAB77},
    {3'd4, 1'b0, 7'd6,  16'h0000, 6'd3,  16'h5AFF},
    {3'd4, 1'b1, 7'd4,  16'h0000, 6'd4,  16'hFFFF},
    {3'd3, 1'b1, 7'd0,  16'h0F0F, 6'd9,  16'h0F0F},
    {3'd3, 1'b0, 7'd0,  16'h00A5, 6'd63, 16'hA5A5},
    {3'd5, 1'b0, 7'd0,  16'h0000, 6'd0,  16'hFFFF},
    {3'd2, 1'b1, 7'd63, 16'h8001, 6'd63, 16'h8001},
    {3'd5, 1'b1, 7'd0,  16'h0000, 6'd63, 16'hFFFF}
  };

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        cs = 1'b0, start_bit = 1'b0, cmd_valid = 1'b0, org = 1'b1;
  logic [2:0]  op = '0;
  logic [6:0]  addr = '0;
  logic [15:0] data = '0;
  logic [5:0]  rd_addr = '0;
  logic [15:0] rd_data, arr_wdata;
  logic        arr_we, arr_all, dout, dout_oe;
  logic [5:0]  arr_addr;
  logic [1:0]  arr_bmask;
  int          n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  nvm_prog_seq #(.PROG_CLKS(P)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cs_i(cs), .start_bit_i(start_bit),
    .cmd_valid_i(cmd_valid), .cmd_op_i(op), .cmd_addr_i(addr), .cmd_data_i(data),
    .org_word_i(org), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .arr_we_o(arr_we), .arr_all_o(arr_all), .arr_addr_o(arr_addr),
    .arr_bmask_o(arr_bmask), .arr_wdata_o(arr_wdata), .dout_o(dout), .dout_oe_o(dout_oe)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [2:0] o, input logic [6:0] a, input logic [15:0] d, input logic g);
    @(negedge clk) cs = 1'b1; start_bit = 1'b1;
    @(negedge clk) start_bit = 1'b0; cmd_valid = 1'b1; op = o; addr = a; data = d; org = g;
    @(negedge clk) cmd_valid = 1'b0;
  endtask

  task automatic drop_cs();
    @(negedge clk) cs = 1'b0;
  endtask

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [15:0] peek(input logic [5:0] w);
    rd_addr = w;
    return 16'h0;
  endfunction

  task automatic read_chk(input string tag, input logic [5:0] w, input logic [15:0] exp);
    rd_addr = w;
    #1 check(tag, rd_data, exp);
  endtask

  function automatic string vtag(input logic [2:0] o, input logic g);
    case (o)
      3'd2:    return g ? "R4" : "R5";
      3'd3:    return "R7";
      3'd4:    return "R6";
      default: return "R8";
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    int zeros;
    waitc(3);
    // R1 reset state
    check("R1 oe", {15'd0, dout_oe}, 16'd0);
    check("R1 we", {15'd0, arr_we}, 16'd0);
    rst_n = 1'b1;
    waitc(2);
    check("R1 oe after release", {15'd0, dout_oe}, 16'd0);

    // R2: enable, erase-all, disable, then a write must be ignored
    send(3'd0, '0, '0, 1'b1);
    send(3'd5, '0, '0, 1'b1);
    drop_cs(); waitc(P + 5);
    send(3'd1, '0, '0, 1'b1);
    send(3'd2, 7'd3, 16'h0000, 1'b1);
    drop_cs(); waitc(P + 5);
    read_chk("R2 write while disabled", 6'd3, 16'hFFFF);
    @(negedge clk) cs = 1'b1;
    waitc(2);
    check("R2 no cycle status", {15'd0, dout_oe}, 16'd0);
    send(3'd0, '0, '0, 1'b1);
    drop_cs(); waitc(2);

    // table of programming commands
    for (int i = 0; i < NV; i++) begin
      send(VEC[i][48:46], VEC[i][44:38], VEC[i][37:22], VEC[i][45]);
      drop_cs(); waitc(P + 5);
      read_chk(vtag(VEC[i][48:46], VEC[i][45]), VEC[i][21:16], VEC[i][15:0]);
    end

    // R3 launch only at CS fall; R9 busy span
    send(3'd2, 7'd10, 16'h1111, 1'b1);
    waitc(4);
    read_chk("R3 no write before CS fall", 6'd10, 16'hFFFF);
    drop_cs();
    @(negedge clk) cs = 1'b1;
    zeros = 0;
    for (int k = 0; k < P + 5; k++) begin
      @(negedge clk);
      if (dout_oe && !dout) zeros++;
    end
    check("R3 busy clocks", 16'(zeros), 16'(P - 1));
    check("R9 ready oe", {15'd0, dout_oe}, 16'd1);
    check("R9 ready value", {15'd0, dout}, 16'd1);
    read_chk("R4 word written", 6'd10, 16'h1111);
    @(negedge clk) start_bit = 1'b1;
    @(negedge clk) start_bit = 1'b0;
    check("R12 start bit release", {15'd0, dout_oe}, 16'd0);

    // R11 commands during a cycle are discarded
    send(3'd2, 7'd20, 16'h2222, 1'b1);
    drop_cs();
    @(negedge clk) cs = 1'b1;
    send(3'd1, '0, '0, 1'b1);
    send(3'd2, 7'd21, 16'h3333, 1'b1);
    check("R9 busy during cycle", {15'd0, dout_oe, dout}, 16'b10);
    waitc(P + 5);
    check("R9 ready after cycle", {15'd0, dout_oe, dout}, 16'b11);
    drop_cs();
    @(negedge clk);
    check("R12 cs fall release", {15'd0, dout_oe}, 16'd0);
    waitc(P + 5);
    read_chk("R4 first write", 6'd20, 16'h2222);
    read_chk("R11 busy write dropped", 6'd21, 16'hFFFF);
    send(3'd2, 7'd22, 16'h4444, 1'b1);
    drop_cs(); waitc(P + 5);
    read_chk("R11 busy disable dropped", 6'd22, 16'h4444);

    // R10 status not shown when CS returns after the cycle
    send(3'd2, 7'd23, 16'h5555, 1'b1);
    drop_cs(); waitc(P + 5);
    @(negedge clk) cs = 1'b1;
    waitc(2);
    check("R10 no late status", {15'd0, dout_oe}, 16'd0);
    read_chk("R4 late write", 6'd23, 16'h5555);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule